// File: doc/BRIEF.md
# Destination-Aware Cell Distributor

This block sits at one input of a first-stage switch in a three-stage Clos fabric. In each cell time it accepts at most one cell and decides which second-stage switch (route) that cell travels through. Route choice does not depend on chance. Cells are sorted into groups by the third-stage switch they are heading for. Each group keeps its own tally of how many of its cells have gone over each route. The least-used route of the cell's group wins, so every group is spread evenly across all second-stage switches, whatever the traffic mix.

A group is the destination address divided by the number of ports per basic switch. Because that number is a power of two, the group is the upper bits of the address. Each group holds one small counter per route and a rotating pointer. The pointer decides between routes with equal counts. When a counter would reach its top value, every counter of that group is halved. This acts as a sliding window, so old history weighs less and no counter ever sticks. The decision is registered and appears one clock after the cell strobe.

Top module: `cell_distributor`

## Requirements
- R1: While reset is asserted, and right after it, `route_valid` is 0 and `route_sel` is 0. Every group record is cleared, so the first cell of any group after reset is given route 0.
- R2: The group of a cell is `cell_dest[DEST_W-1:ROUTE_W]`, the address divided by `N_ROUTES`. The low `ROUTE_W` address bits have no effect on the route chosen.
- R3: When `cell_valid` is 1 at a clock edge, `route_valid` is 1 after that edge and `route_sel` carries the route chosen for that cell.
- R4: Within one group, starting from a cleared record, successive cells get routes 0, 1, …, N_ROUTES-1 and then wrap to 0.
- R5: Groups are independent. Cells of one group never change the route sequence seen by another group.
- R6: A cycle with `cell_valid` at 0 updates no record. After it, `route_valid` is 0 and `route_sel` keeps its previous value.
- R7: The chosen route is the one with the smallest count in its group. Ties go to the first route at or after the group's pointer, taken cyclically. The pointer then moves to one past the chosen route. Within a group, no two route counts ever differ by more than one.
- R8: When the chosen route's incremented count would equal 2^CNT_W-1, all counts of that group are halved, rounding down. A stored count never equals 2^CNT_W-1, and the route sequence of R4 continues unbroken across any number of cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | A cell is present this cell time |
| cell_dest | input | DEST_W | Destination output-port address of the cell |
| route_valid | output | 1 | `route_sel` holds a new decision |
| route_sel | output | ROUTE_W | Index of the chosen second-stage switch |

## Verification
The bench builds the block with four routes, four groups and 3-bit counters. With 3-bit counters, a single group reaches the halving point after only about two dozen cells. A forty-cell burst to one group therefore crosses the window reset more than once, and shows whether the rotation survives it. Four groups make a 4-bit address. This is small enough that a short vector table can interleave several groups with idle cycles, and can vary the low address bits inside one group.

// File: rtl/cd_pkg.sv
package cd_pkg;

   // Width of an index able to address v items, never below one bit.
   function automatic int unsigned cd_idx_bits(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

   // True when v is a power of two and at least two.
   function automatic bit cd_is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cd_route_pick.sv
module cd_route_pick
   import cd_pkg::*;
#(
   parameter int unsigned N_ROUTES = 4,
   parameter int unsigned CNT_W    = 8,
   localparam int unsigned ROUTE_W = cd_idx_bits(N_ROUTES)
) (
   input  logic [N_ROUTES-1:0][CNT_W-1:0] cnt_i,
   input  logic [ROUTE_W-1:0]             ptr_i,
   output logic [ROUTE_W-1:0]             pick_o
);

   logic [ROUTE_W-1:0] best_idx;
   logic [CNT_W-1:0]   best_cnt;
   logic [ROUTE_W-1:0] scan_idx;

   // Scan routes in rotated order from the pointer; strict compare keeps
   // the earliest candidate on a tie.
   always_comb begin
      best_idx = ptr_i;
      best_cnt = cnt_i[ptr_i];
      scan_idx = ptr_i;
      for (int unsigned k = 1; k < N_ROUTES; k++) begin
         scan_idx = ptr_i + ROUTE_W'(k);
         if (cnt_i[scan_idx] < best_cnt) begin
            best_idx = scan_idx;
            best_cnt = cnt_i[scan_idx];
         end
      end
   end

   assign pick_o = best_idx;

   // The pick is never worse than the pointer's own candidate.
   always_comb begin
      AST_PICK_MIN: assert (cnt_i[pick_o] <= cnt_i[ptr_i]); // R7
   end

endmodule

// File: rtl/cd_group_rec.sv
module cd_group_rec
   import cd_pkg::*;
#(
   parameter int unsigned N_ROUTES = 4,
   parameter int unsigned CNT_W    = 8,
   localparam int unsigned ROUTE_W = cd_idx_bits(N_ROUTES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           upd_i,
   input  logic [ROUTE_W-1:0]             sel_i,
   output logic [N_ROUTES-1:0][CNT_W-1:0] cnt_o,
   output logic [ROUTE_W-1:0]             ptr_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [N_ROUTES-1:0][CNT_W-1:0] cnt_q;
   logic [N_ROUTES-1:0][CNT_W-1:0] cnt_nxt;
   logic [ROUTE_W-1:0]             ptr_q;
   logic [CNT_W-1:0]               bumped;
   logic                           window_end;

   assign bumped     = cnt_q[sel_i] + 1'b1;
   assign window_end = (bumped == CNT_TOP);

   always_comb begin
      for (int unsigned r = 0; r < N_ROUTES; r++) begin
         cnt_nxt[r] = (ROUTE_W'(r) == sel_i) ? bumped : cnt_q[r];
         if (window_end) begin
            cnt_nxt[r] = cnt_nxt[r] >> 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ptr_q <= '0;
      end else if (upd_i) begin
         cnt_q <= cnt_nxt;
         ptr_q <= sel_i + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ptr_o = ptr_q;

   for (genvar r = 0; r < N_ROUTES; r++) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q[r] != CNT_TOP); // R8
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !upd_i |=> $stable(cnt_q[r])); // R6
      AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
         ((CNT_W+1)'(cnt_q[r]) <= (CNT_W+1)'(cnt_q[0]) + 1'b1) &&
         ((CNT_W+1)'(cnt_q[0]) <= (CNT_W+1)'(cnt_q[r]) + 1'b1)); // R7
   end

endmodule

// File: rtl/cell_distributor.sv
module cell_distributor
   import cd_pkg::*;
#(
   parameter int unsigned N_ROUTES = 4,
   parameter int unsigned N_GROUPS = 4,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned ROUTE_W  = cd_idx_bits(N_ROUTES),
   parameter int unsigned GROUP_W  = cd_idx_bits(N_GROUPS),
   parameter int unsigned DEST_W   = ROUTE_W + GROUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cell_valid,
   input  logic [DEST_W-1:0]  cell_dest,
   output logic               route_valid,
   output logic [ROUTE_W-1:0] route_sel
);

   // Elaboration-time parameter checks.
   if (!cd_is_pow2(N_ROUTES)) begin : g_bad_routes
      $error("cell_distributor: N_ROUTES must be a power of two, at least 2");
   end
   if (!cd_is_pow2(N_GROUPS)) begin : g_bad_groups
      $error("cell_distributor: N_GROUPS must be a power of two, at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cell_distributor: CNT_W must be at least 2");
   end
   if (DEST_W != ROUTE_W + GROUP_W) begin : g_bad_dest
      $error("cell_distributor: DEST_W must equal ROUTE_W + GROUP_W");
   end

   logic [GROUP_W-1:0]                             grp_idx;
   logic [N_GROUPS-1:0]                            grp_upd;
   logic [N_GROUPS-1:0][N_ROUTES-1:0][CNT_W-1:0]   all_cnt;
   logic [N_GROUPS-1:0][ROUTE_W-1:0]               all_ptr;
   logic [N_ROUTES-1:0][CNT_W-1:0]                 cur_cnt;
   logic [ROUTE_W-1:0]                             cur_ptr;
   logic [ROUTE_W-1:0]                             pick;

   // Third-stage group is the address divided by the per-switch port count.
   assign grp_idx = cell_dest[DEST_W-1:ROUTE_W];

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      assign grp_upd[g] = cell_valid && (grp_idx == GROUP_W'(g));

      cd_group_rec #(
         .N_ROUTES (N_ROUTES),
         .CNT_W    (CNT_W)
      ) i_rec (
         .clk   (clk),
         .rst_n (rst_n),
         .upd_i (grp_upd[g]),
         .sel_i (pick),
         .cnt_o (all_cnt[g]),
         .ptr_o (all_ptr[g])
      );
   end

   assign cur_cnt = all_cnt[grp_idx];
   assign cur_ptr = all_ptr[grp_idx];

   cd_route_pick #(
      .N_ROUTES (N_ROUTES),
      .CNT_W    (CNT_W)
   ) i_pick (
      .cnt_i  (cur_cnt),
      .ptr_i  (cur_ptr),
      .pick_o (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_sel   <= '0;
      end else begin
         route_valid <= cell_valid;
         if (cell_valid) begin
            route_sel <= pick;
         end
      end
   end

   AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_upd)); // R5
   AST_LATENCY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid |=> route_valid); // R3
   AST_LATENCY_DN: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_valid |=> !route_valid); // R6
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_valid |=> $stable(route_sel)); // R6

endmodule

// File: tb/test_cell_distributor.sv
module test_cell_distributor;

   localparam int unsigned N_ROUTES = 4;
   localparam int unsigned N_GROUPS = 4;
   localparam int unsigned CNT_W    = 3;
   localparam int unsigned ROUTE_W  = 2;
   localparam int unsigned DEST_W   = 4;
   localparam int unsigned N_VEC    = 13;

   // {cell_valid, cell_dest[3:0], exp_valid, exp_route[1:0]}
   localparam logic [7:0] VEC [N_VEC] = '{
      {1'b1, 4'h0, 1'b1, 2'd0},  // g0 first -> 0 (R4)
      {1'b1, 4'h1, 1'b1, 2'd1},  // g0 -> 1
      {1'b1, 4'h9, 1'b1, 2'd0},  // g2 first -> 0 (R5)
      {1'b0, 4'h0, 1'b0, 2'd0},  // idle, hold (R6)
      {1'b1, 4'h3, 1'b1, 2'd2},  // g0 -> 2
      {1'b1, 4'hA, 1'b1, 2'd1},  // g2 -> 1
      {1'b1, 4'hF, 1'b1, 2'd0},  // g3 first -> 0
      {1'b1, 4'h2, 1'b1, 2'd3},  // g0 -> 3
      {1'b1, 4'h0, 1'b1, 2'd0},  // g0 wraps -> 0
      {1'b0, 4'h4, 1'b0, 2'd0},  // idle with g1 address (R6)
      {1'b1, 4'h5, 1'b1, 2'd0},  // g1 untouched by idle -> 0
      {1'b1, 4'h8, 1'b1, 2'd2},  // g2 -> 2
      {1'b1, 4'h6, 1'b1, 2'd1}   // g1 -> 1
   };

   logic               clk = 1'b0;
   logic               rst_n;
   logic               cell_valid;
   logic [DEST_W-1:0]  cell_dest;
   logic               route_valid;
   logic [ROUTE_W-1:0] route_sel;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   cell_distributor #(
      .N_ROUTES (N_ROUTES),
      .N_GROUPS (N_GROUPS),
      .CNT_W    (CNT_W)
   ) i_cell_distributor (
      .clk         (clk),
      .rst_n       (rst_n),
      .cell_valid  (cell_valid),
      .cell_dest   (cell_dest),
      .route_valid (route_valid),
      .route_sel   (route_sel)
   );

   task automatic check(input string req, input logic exp_v, input logic [ROUTE_W-1:0] exp_r);
      checks++;
      if (route_valid !== exp_v || route_sel !== exp_r) begin
         failures++;
         $display("FAIL %s: valid=%0b route=%0d expected valid=%0b route=%0d",
                  req, route_valid, route_sel, exp_v, exp_r);
      end
   endtask

   // Drive on a falling edge, then sample 2 ns after the next rising edge.
   task automatic step(input logic v, input logic [DEST_W-1:0] d);
      @(negedge clk);
      cell_valid = v;
      cell_dest  = d;
      @(posedge clk);
      #2;
   endtask

   initial begin
      rst_n      = 1'b0;
      cell_valid = 1'b0;
      cell_dest  = '0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset", 1'b0, 2'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: groups interleaved, idle cycles, low address bits varied.
      for (int i = 0; i < N_VEC; i++) begin
         step(VEC[i][7], VEC[i][6:3]);
         check($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i][2], VEC[i][1:0]);
      end

      // Long burst to group 3 (one cell already routed to 0): crosses
      // the halving point of 3-bit counters several times.
      for (int i = 0; i < 40; i++) begin
         step(1'b1, DEST_W'(12 + (i % 4)));
         check($sformatf("R8 R7 R2 burst%0d", i), 1'b1, ROUTE_W'((1 + i) % 4));
      end
      step(1'b0, 4'hC);
      check("R6 idle after burst", 1'b0, ROUTE_W'(40 % 4));

      // Group 2 kept its place during the burst (last route 2 -> next 3).
      step(1'b1, 4'hB);
      check("R5 g2 after burst", 1'b1, 2'd3);

      // Reset mid-stream with a cell presented: record and outputs clear.
      @(negedge clk);
      rst_n      = 1'b0;
      cell_valid = 1'b1;
      cell_dest  = 4'hD;
      @(posedge clk);
      #2;
      check("R1 reset mid-stream", 1'b0, 2'd0);
      @(negedge clk);
      rst_n      = 1'b1;
      cell_valid = 1'b0;
      step(1'b1, 4'hE);
      check("R1 g3 cleared", 1'b1, 2'd0);
      step(1'b1, 4'h7);
      check("R1 g1 cleared", 1'b1, 2'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule